// File: doc/BRIEF.md
# Binary Hit-Pattern Pad Readout

This block is the digital back end of a 64-pad readout with one bit per pad. The comparators ahead of it have already thresholded every pad against one shared threshold level, which this block holds in a configuration register that drives the threshold converter. On every cycle of the front-end clock the block registers which pads fired. It tags that frame with a coarse timestamp that counts front-end clock cycles, so one count is one 100 ns period at 10 MHz. A counter-clear input lets many boards share a common time base.

The block forms a packet from a frame and a timestamp in one of two modes. In self-triggered mode every frame with at least one hit becomes a packet. In triggered mode only an external trigger produces a packet, and that packet may carry an all-zero pattern. A latency line of up to 16 frames can be switched into the path. When it is on, a late trigger picks the frame that was sampled a programmed number of cycles earlier. Packets cross into an independent readout clock through a 16-entry asynchronous FIFO with Gray-coded pointers. When that FIFO is full, new packets are dropped and counted.

Top module: `hitro_top`

## Requirements
- R1: After reset, `rd_valid` is 0, `ovf_count` is 0 and `thr_level` is 0.
- R2: The timestamp advances by one per front-end clock cycle. A packet carries the timestamp value of the cycle in which its pads were sampled. With `ts_clear` high in a cycle, the next cycle's timestamp is 0.
- R3: With `cfg_trig_mode`=0 (self-triggered), every frame with at least one pad set yields one packet whose `rd_pattern` bit i equals pad i. Frames with no pad set yield nothing.
- R4: With `cfg_trig_mode`=1 (triggered), a packet is produced exactly in the cycles with `ext_trig` high, whatever the pads show, and no packet is produced otherwise.
- R5: With `cfg_pipe_en`=1, the frame chosen in cycle k is the one sampled in cycle k-L, where L = `cfg_lat_m1`+1 (1 to 16).
- R6: With `cfg_pipe_en`=0, the frame chosen in cycle k is the pads and timestamp of cycle k itself.
- R7: When the FIFO holds 16 packets, a new packet is discarded and `ovf_count` rises by one (saturating). The 16 stored packets are kept intact.
- R8: Packets leave in write order. `rd_valid` is high while the FIFO holds a packet, and a readout-clock edge with `rd_en` high removes the packet shown.
- R9: `thr_level` loads `thr_din` on a front-end edge with `thr_wr` high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fe_clk | input | 1 | Front-end sampling clock (10 MHz) |
| fe_arst_n | input | 1 | Asynchronous active-low reset, front-end domain |
| rd_clk | input | 1 | Readout clock, independent of fe_clk |
| rd_arst_n | input | 1 | Asynchronous active-low reset, readout domain |
| pad_hit | input | 64 | Thresholded comparator outputs, one per pad |
| cfg_trig_mode | input | 1 | 0 self-triggered, 1 external trigger |
| cfg_pipe_en | input | 1 | Route frames through the latency line |
| cfg_lat_m1 | input | 4 | Latency in frames minus one |
| thr_wr | input | 1 | Load strobe for the threshold register |
| thr_din | input | 8 | New threshold level |
| thr_level | output | 8 | Shared threshold level to the converter |
| ts_clear | input | 1 | Synchronous timestamp clear |
| ext_trig | input | 1 | External trigger, one cycle per trigger |
| ovf_count | output | 16 | Count of packets dropped on a full FIFO |
| rd_en | input | 1 | Pop the shown packet (readout domain) |
| rd_valid | output | 1 | A packet is shown on the read outputs |
| rd_pattern | output | 64 | Hit pattern of the shown packet |
| rd_stamp | output | 24 | Timestamp of the shown packet |

## Verification
The assertions assume three things about the inputs. The configuration inputs change only between frames, with the front-end clock running. `ts_clear` is synchronous to that clock. `rd_en` belongs to the readout domain. The bench drives every front-end input on the falling edge of `fe_clk` and drives `rd_en` on the falling edge of `rd_clk`. It changes the mode and the latency only while the pads are quiet or when the history of past frames is already defined. Before the overflow sweep it drains the FIFO and lets the pointer synchronisers settle, so the drop count it expects is exact.

// File: rtl/hitro_pkg.sv
package hitro_pkg;
  typedef enum logic {
    MODE_SELF = 1'b0,
    MODE_TRIG = 1'b1
  } trig_mode_e;

  localparam int HITRO_PADS    = 64;
  localparam int HITRO_STAMP_W = 24;
endpackage

// File: rtl/hitro_rst_sync.sv
module hitro_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n = hold_q;
endmodule

// File: rtl/hitro_tap_line.sv
module hitro_tap_line #(
  parameter int W = 88,
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   din,
  output logic [N*W-1:0] taps
);
  logic [W-1:0] stage_q [N];
  logic [W-1:0] stage_d [N];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_comb stage_d[g] = din;
      end else begin : g_body
        always_comb stage_d[g] = stage_q[g-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d[g];
      end

      assign taps[g*W +: W] = stage_q[g];
    end
  endgenerate

  // R5: every stage holds what its predecessor held one cycle earlier
  generate
    if (N > 1) begin : g_chk
      p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stage_q[1] == $past(stage_q[0])));
    end
  endgenerate
endmodule

// File: rtl/hitro_afifo.sv
module hitro_afifo #(
  parameter int W  = 88,
  parameter int AW = 4
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin_q, wbin_d, wgray_q;
  logic [PW-1:0] rbin_q, rbin_d, rgray_q;
  logic [PW-1:0] rg_s1_q, rg_s2_q;
  logic [PW-1:0] wg_s1_q, wg_s2_q;
  logic          do_wr, do_rd;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // write side
  assign do_wr  = wr_en & ~full;
  assign wbin_d = do_wr ? wbin_q + 1'b1 : wbin_q;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      rg_s1_q <= '0;
      rg_s2_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= to_gray(wbin_d);
      rg_s1_q <= rgray_q;
      rg_s2_q <= rg_s1_q;
    end
  end

  always_ff @(posedge wclk) begin
    if (do_wr) mem[wbin_q[AW-1:0]] <= wr_data;
  end

  generate
    if (AW > 1) begin : g_full_wide
      assign full = (wgray_q == {~rg_s2_q[PW-1:PW-2], rg_s2_q[PW-3:0]});
    end else begin : g_full_narrow
      assign full = (wgray_q == ~rg_s2_q);
    end
  endgenerate

  // read side
  assign do_rd   = rd_en & ~empty;
  assign rbin_d  = do_rd ? rbin_q + 1'b1 : rbin_q;
  assign empty   = (rgray_q == wg_s2_q);
  assign rd_data = mem[rbin_q[AW-1:0]];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      wg_s1_q <= '0;
      wg_s2_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= to_gray(rbin_d);
      wg_s1_q <= wgray_q;
      wg_s2_q <= wg_s1_q;
    end
  end

  // R7: a full FIFO never advances its write pointer
  p_full_blocks_write_r7: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |=> (wbin_q == $past(wbin_q)));

  // R8: popping an empty FIFO leaves the read pointer alone
  p_empty_blocks_read_r8: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty |=> (rbin_q == $past(rbin_q)));

  // R8: the synchronised write pointer changes by at most one Gray step
  p_gray_single_step_r8: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(wg_s1_q ^ $past(wg_s1_q)) <= 1);
endmodule

// File: rtl/hitro_top.sv
module hitro_top
  import hitro_pkg::*;
#(
  parameter int NPADS   = HITRO_PADS,
  parameter int TS_W    = HITRO_STAMP_W,
  parameter int MAX_LAT = 16,
  parameter int FIFO_AW = 4,
  parameter int THR_W   = 8,
  parameter int OVF_W   = 16,
  localparam int LAT_W  = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1
) (
  input  logic              fe_clk,
  input  logic              fe_arst_n,
  input  logic              rd_clk,
  input  logic              rd_arst_n,
  input  logic [NPADS-1:0]  pad_hit,
  input  logic              cfg_trig_mode,
  input  logic              cfg_pipe_en,
  input  logic [LAT_W-1:0]  cfg_lat_m1,
  input  logic              thr_wr,
  input  logic [THR_W-1:0]  thr_din,
  output logic [THR_W-1:0]  thr_level,
  input  logic              ts_clear,
  input  logic              ext_trig,
  output logic [OVF_W-1:0]  ovf_count,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [NPADS-1:0]  rd_pattern,
  output logic [TS_W-1:0]   rd_stamp
);
  localparam int FW = NPADS + TS_W;

  logic fe_rst_n, rd_rst_n;

  hitro_rst_sync u_fe_rst (.clk(fe_clk), .arst_n(fe_arst_n), .rst_n(fe_rst_n));
  hitro_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rd_arst_n), .rst_n(rd_rst_n));

  // timestamp counter
  logic [TS_W-1:0] ts_q, ts_d;
  always_comb ts_d = ts_clear ? '0 : ts_q + 1'b1;

  always_ff @(posedge fe_clk or negedge fe_rst_n) begin
    if (!fe_rst_n) ts_q <= '0;
    else           ts_q <= ts_d;
  end

  // shared threshold register
  logic [THR_W-1:0] thr_q, thr_d;
  always_comb thr_d = thr_wr ? thr_din : thr_q;

  always_ff @(posedge fe_clk or negedge fe_rst_n) begin
    if (!fe_rst_n) thr_q <= '0;
    else           thr_q <= thr_d;
  end
  assign thr_level = thr_q;

  // latency line
  logic [FW-1:0]         cap_word;
  logic [MAX_LAT*FW-1:0] tap_bus;
  logic [FW-1:0]         tap_pick;
  logic [FW-1:0]         cand;

  assign cap_word = {pad_hit, ts_q};

  hitro_tap_line #(.W(FW), .N(MAX_LAT)) u_taps (
    .clk   (fe_clk),
    .rst_n (fe_rst_n),
    .din   (cap_word),
    .taps  (tap_bus)
  );

  always_comb begin
    tap_pick = tap_bus[FW-1:0];
    for (int i = 0; i < MAX_LAT; i++) begin
      if (cfg_lat_m1 == LAT_W'(i)) tap_pick = tap_bus[i*FW +: FW];
    end
  end

  assign cand = cfg_pipe_en ? tap_pick : cap_word;

  // packet selection
  trig_mode_e mode;
  logic       push_req, fifo_wr, fifo_full, fifo_empty;
  logic [FW-1:0] rd_word;

  assign mode = trig_mode_e'(cfg_trig_mode);

  always_comb begin
    unique case (mode)
      MODE_TRIG: push_req = ext_trig;
      default:   push_req = |cand[FW-1:TS_W];
    endcase
  end

  assign fifo_wr = push_req & ~fifo_full;

  // overflow counter
  logic [OVF_W-1:0] ovf_q, ovf_d;
  logic             ovf_en;
  assign ovf_en = push_req & fifo_full & (ovf_q != {OVF_W{1'b1}});
  always_comb ovf_d = ovf_en ? ovf_q + 1'b1 : ovf_q;

  always_ff @(posedge fe_clk or negedge fe_rst_n) begin
    if (!fe_rst_n) ovf_q <= '0;
    else           ovf_q <= ovf_d;
  end
  assign ovf_count = ovf_q;

  hitro_afifo #(.W(FW), .AW(FIFO_AW)) u_fifo (
    .wclk    (fe_clk),
    .wrst_n  (fe_rst_n),
    .wr_en   (fifo_wr),
    .wr_data (cand),
    .full    (fifo_full),
    .rclk    (rd_clk),
    .rrst_n  (rd_rst_n),
    .rd_en   (rd_en),
    .rd_data (rd_word),
    .empty   (fifo_empty)
  );

  assign rd_valid   = ~fifo_empty;
  assign rd_pattern = rd_word[FW-1:TS_W];
  assign rd_stamp   = rd_word[TS_W-1:0];

  // R2: clear drives the stamp to zero on the next edge
  p_ts_clear_r2: assert property (@(posedge fe_clk) disable iff (!fe_rst_n)
    ($past(fe_rst_n) && $past(ts_clear)) |-> (ts_q == '0));

  // R2: without clear the stamp advances by exactly one
  p_ts_step_r2: assert property (@(posedge fe_clk) disable iff (!fe_rst_n)
    ($past(fe_rst_n) && !$past(ts_clear)) |-> (ts_q == $past(ts_q) + 1'b1));

  // R4: in triggered mode nothing is written without a trigger
  p_trig_gate_r4: assert property (@(posedge fe_clk) disable iff (!fe_rst_n)
    (cfg_trig_mode && !ext_trig) |-> !fifo_wr);

  // R7: the drop counter moves only by one and only when the FIFO was full
  p_ovf_step_r7: assert property (@(posedge fe_clk) disable iff (!fe_rst_n)
    (ovf_q != $past(ovf_q)) |-> ($past(fifo_full) && (ovf_q == $past(ovf_q) + 1'b1)));

  // R9: the threshold holds without a write strobe
  p_thr_hold_r9: assert property (@(posedge fe_clk) disable iff (!fe_rst_n)
    !$past(thr_wr) |-> $stable(thr_q));
endmodule

// File: tb/hitro_top_test.sv
module hitro_top_test;
  localparam int FE_PERIOD = 100;
  localparam int RD_PERIOD = 30;
  localparam int HN        = 4096;
  localparam int EN        = 2048;

  logic        fe_clk = 1'b0, rd_clk = 1'b0;
  logic        fe_arst_n, rd_arst_n;
  logic [63:0] pad_hit;
  logic        cfg_trig_mode, cfg_pipe_en;
  logic [3:0]  cfg_lat_m1;
  logic        thr_wr;
  logic [7:0]  thr_din, thr_level;
  logic        ts_clear, ext_trig;
  logic [15:0] ovf_count;
  logic        rd_en, rd_valid;
  logic [63:0] rd_pattern;
  logic [23:0] rd_stamp;

  hitro_top uut (
    .fe_clk(fe_clk), .fe_arst_n(fe_arst_n), .rd_clk(rd_clk), .rd_arst_n(rd_arst_n),
    .pad_hit(pad_hit), .cfg_trig_mode(cfg_trig_mode), .cfg_pipe_en(cfg_pipe_en),
    .cfg_lat_m1(cfg_lat_m1), .thr_wr(thr_wr), .thr_din(thr_din), .thr_level(thr_level),
    .ts_clear(ts_clear), .ext_trig(ext_trig), .ovf_count(ovf_count), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_pattern(rd_pattern), .rd_stamp(rd_stamp)
  );

  always #(FE_PERIOD/2) fe_clk = ~fe_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  int    checks = 0, failures = 0;
  string cur_req = "R3";

  task automatic chk(input bit ok, input string req, input logic [87:0] act, input logic [87:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // frame history and expected packet list
  logic [63:0] hp [HN];
  logic [23:0] ht [HN];
  logic [63:0] ep [EN];
  logic [23:0] et [EN];
  int          cyc = 100, exp_cnt = 0, rd_idx = 0;
  logic [23:0] mts = '0;
  bit          model_on = 0, reader_on = 0;

  initial begin
    for (int i = 0; i < HN; i++) begin hp[i] = '0; ht[i] = '0; end
  end

  always @(posedge fe_clk) begin
    if (model_on) begin
      int idx;
      logic [63:0] cp;
      logic [23:0] ct;
      bit push;
      hp[cyc % HN] = pad_hit;
      ht[cyc % HN] = mts;
      idx = cfg_pipe_en ? cyc - (int'(cfg_lat_m1) + 1) : cyc;
      cp = hp[idx % HN];
      ct = ht[idx % HN];
      push = cfg_trig_mode ? ext_trig : (cp != '0);
      if (push) begin
        ep[exp_cnt % EN] = cp;
        et[exp_cnt % EN] = ct;
        exp_cnt++;
      end
      mts = ts_clear ? 24'd0 : mts + 24'd1;
      cyc++;
    end
  end

  // reader in the readout domain
  always @(negedge rd_clk) begin
    if (reader_on && rd_valid) begin
      if (rd_idx < exp_cnt) begin
        chk(rd_pattern == ep[rd_idx % EN], {cur_req, " pattern"}, 88'(rd_pattern), 88'(ep[rd_idx % EN]));
        chk(rd_stamp == et[rd_idx % EN], {cur_req, " stamp"}, 88'(rd_stamp), 88'(et[rd_idx % EN]));
      end else begin
        chk(1'b0, {cur_req, " unexpected packet"}, 88'(rd_pattern), 88'(0));
      end
      rd_idx++;
      rd_en = 1'b1;
    end else begin
      rd_en = 1'b0;
    end
  end

  task automatic frame(input logic [63:0] pat, input logic trig);
    @(negedge fe_clk);
    pad_hit  = pat;
    ext_trig = trig;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) frame('0, 1'b0);
  endtask

  task automatic drain();
    int t = 0;
    idle(3);
    while (rd_idx < exp_cnt && t < 5000) begin
      @(negedge rd_clk);
      t++;
    end
    repeat (20) @(negedge rd_clk);
    // R8: every expected packet arrived and nothing else is pending
    chk(rd_idx == exp_cnt, {cur_req, " R8 packet count"}, 88'(rd_idx), 88'(exp_cnt));
    chk(!rd_valid, {cur_req, " R8 fifo empty after drain"}, 88'(rd_valid), 88'(0));
  endtask

  function automatic logic [63:0] mkpat(input int i);
    return {32'(i) * 32'h9E3779B1, 32'(i) ^ 32'h5A5A_0001};
  endfunction

  initial begin
    fe_arst_n = 1'b0; rd_arst_n = 1'b0;
    pad_hit = '0; cfg_trig_mode = 1'b0; cfg_pipe_en = 1'b0; cfg_lat_m1 = '0;
    thr_wr = 1'b0; thr_din = '0; ts_clear = 1'b0; ext_trig = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge fe_clk);
    fe_arst_n = 1'b1; rd_arst_n = 1'b1;
    repeat (5) @(negedge fe_clk);

    // R1 reset state
    chk(rd_valid == 1'b0, "R1 rd_valid", 88'(rd_valid), 88'(0));
    chk(ovf_count == '0, "R1 ovf_count", 88'(ovf_count), 88'(0));
    chk(thr_level == '0, "R1 thr_level", 88'(thr_level), 88'(0));

    // R9 threshold register
    thr_din = 8'hA5; thr_wr = 1'b1;
    @(negedge fe_clk);
    thr_wr = 1'b0; thr_din = 8'h3C;
    chk(thr_level == 8'hA5, "R9 load", 88'(thr_level), 88'(8'hA5));
    repeat (3) @(negedge fe_clk);
    chk(thr_level == 8'hA5, "R9 hold", 88'(thr_level), 88'(8'hA5));

    // common time base
    model_on = 1; reader_on = 1;
    ts_clear = 1'b1;
    @(negedge fe_clk);
    ts_clear = 1'b0;

    // R3 self-triggered sweep: walking one with quiet frames between
    cur_req = "R3";
    for (int i = 0; i < 64; i++) begin
      frame(64'd1 << i, 1'b0);
      frame('0, 1'b0);
    end
    frame('1, 1'b0);
    frame(64'h8000_0000_0000_0001, 1'b0);
    frame(mkpat(7), 1'b0);
    drain();

    // R2 stamps across a clear
    cur_req = "R2";
    frame(mkpat(11), 1'b0);
    ts_clear = 1'b1;
    frame(mkpat(12), 1'b0);
    ts_clear = 1'b0;
    frame(mkpat(13), 1'b0);
    frame(mkpat(14), 1'b0);
    drain();

    // R4 and R6 triggered without latency line
    cur_req = "R4 R6";
    cfg_trig_mode = 1'b1;
    for (int i = 0; i < 48; i++) frame(mkpat(100 + i), (i % 5) == 2);
    frame('0, 1'b1);
    idle(4);
    drain();

    // R5 latency sweep over every setting
    cur_req = "R5";
    cfg_pipe_en = 1'b1;
    for (int l = 1; l <= 16; l++) begin
      cfg_lat_m1 = 4'(l - 1);
      for (int i = 0; i < 20; i++) frame(mkpat(300 + l * 20 + i), i == 18);
      frame('0, 1'b0);
    end
    drain();

    // R7 overflow: 20 frames into a 16-entry FIFO with nothing read
    cur_req = "R7";
    cfg_trig_mode = 1'b0; cfg_pipe_en = 1'b0;
    idle(6);
    reader_on = 0;
    begin
      int start;
      start = exp_cnt;
      for (int i = 0; i < 20; i++) frame(mkpat(900 + i), 1'b0);
      idle(4);
      exp_cnt = start + 16;
    end
    chk(ovf_count == 16'd4, "R7 ovf_count", 88'(ovf_count), 88'(4));
    reader_on = 1;
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(FE_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule